// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns two active-low external interrupt pins, called A and B, into interrupt requests that a small interrupt controller can take. Each pin first passes through a two-flop synchronizer. Software programs a sense-select bit for each pin. In low-level mode the request follows the pin. In falling-edge mode a falling edge sets a sticky pending flag, and that flag stays set until software clears it. When the chip is in a stop or wait low-power state, both pins are treated as level sensitive, whatever their sense-select bits hold.

Each request also carries a 2-bit priority code that software sets. The code 00 disables the request. The code 01 means level 0, and larger codes mean higher levels. The request output is raised only when its source is active and its code is not 00. The priority codes are driven out so that a downstream arbiter can use them.

Software reaches the block through a register port with a single-cycle write and a combinational read. Address 0 is the control/status word and address 1 is the priority word. Addresses 2 and 3 are unused.

Top module: `extirq_cond`

## Requirements
- R1: Control word bits 2 (pin A) and 3 (pin B) are read-only. Each returns the synchronized pin level, with 1 meaning high, and follows a change at the pin two clock edges later. Both bits read 1 out of reset.
- R2: Control word bit 0 (pin A) and bit 1 (pin B) are the sense-select bits, where 0 means low level and 1 means falling edge. Both reset to 0.
- R3: In effective level mode, a pin's request is active while its synchronized level is low and drops as soon as the pin is high again. Nothing is latched in this mode.
- R4: In effective edge mode, a falling edge of the synchronized level sets a pending flag. The flag stays set after the pin returns high. The request state can be read at bit 6 (A) and bit 7 (B) of the control word.
- R5: Writing 1 to control bit 4 clears A's pending flag, and writing 1 to bit 5 clears B's. If a falling edge is detected in the same cycle as a clear, the pending flag is set. Both bits read 0.
- R6: While the low-power input is high, both pins behave in level mode regardless of their sense-select bits. A falling edge during low power latches nothing.
- R7: A pending flag that is set when the low-power input rises stays set until it is cleared by a write.
- R8: The priority word (address 1) holds A's code at bits [1:0] and B's code at bits [3:2]. Both codes reset to 00, and they are driven on `prio_o` with the same bit layout.
- R9: `irq_o[i]` is 1 exactly when pin i's request is active and its priority code is not 00.
- R10: Control bits 15:8 and priority bits 15:4 read 0, and writes to them have no effect. Addresses 2 and 3 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_n | input | 2 | Asynchronous interrupt pins, active low; bit 0 = A, bit 1 = B |
| lp_mode | input | 1 | High while the chip is in stop or wait low-power state |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| irq_o | output | 2 | Interrupt requests; bit 0 = A, bit 1 = B |
| prio_o | output | 4 | Priority codes; [1:0] = A, [3:2] = B |

## Verification
A software clear of a pending flag and a fresh falling edge can arrive in the same cycle, and the block must keep the flag set. The bench drops pin A in edge mode and counts edges through the synchronizer so that the clear write is captured on the exact edge where the falling edge is detected. It then expects the pending bit to read 1. A write one cycle later must clear the flag, which shows the clear path works on its own. The bench also sweeps every combination of sense, low-power state, priority codes and pin pattern, and checks each one.

// File: rtl/extirq_pkg.sv
// Package: shared sizes and register layout for the interrupt pin conditioner.
// Assumes exactly two pins; the bit positions below are what software decodes.
package extirq_pkg;
    localparam int NUM_PINS  = 2;
    localparam int PRIO_W    = 2;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int SYNC_LEN  = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_PRIO = 2'd1;

    localparam int SENSE_LSB  = 0;
    localparam int MIRROR_LSB = SENSE_LSB + NUM_PINS;
    localparam int CLR_LSB    = MIRROR_LSB + NUM_PINS;
    localparam int PEND_LSB   = CLR_LSB + NUM_PINS;
    localparam int CTRL_USED  = PEND_LSB + NUM_PINS;
    localparam int PRIO_USED  = NUM_PINS * PRIO_W;
endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Brings one asynchronous active-low pin into the clock domain through a
// chain of STAGES flops, plus one extra flop used for falling-edge detection.
// Assumes the pin idles high, so every flop resets to 1 and no edge is seen at
// reset release.
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level,
    output logic fall
);
    logic [STAGES:0] chain_q;

    // Shift the pin through the synchronizer and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], pin_n};
    end

    // Synchronized level and a one-cycle falling-edge pulse.
    always_comb begin
        level = chain_q[STAGES-1];
        fall  = chain_q[STAGES] & ~chain_q[STAGES-1];
    end
endmodule

// File: rtl/irq_channel.sv
// Module: irq_channel
// Request state for one pin. In edge mode a falling edge sets a sticky pending
// flag. In level mode the request follows the low synchronized level and the
// flag is only held. A detected edge has priority over a clear in the same cycle.
// Assumes edge_mode already includes the low-power override.
module irq_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic level,
    input  logic fall,
    input  logic clr,
    output logic pend_q,
    output logic active
);
    // Sticky pending flag: set by an edge in edge mode, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend_q <= 1'b0;
        else if (edge_mode && fall) pend_q <= 1'b1;
        else if (clr)               pend_q <= 1'b0;
    end

    // Request is the latched flag or, in level mode, a low pin.
    always_comb begin
        active = pend_q | (~edge_mode & ~level);
    end
endmodule

// File: rtl/irq_regs.sv
// Module: irq_regs
// Register file: sense-select bits, priority codes, clear strobes, and the
// read mux. Assumes a single-cycle write and a combinational read. Unused
// addresses and reserved bits read 0.
module irq_regs
    import extirq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NUM_PINS-1:0]        lvl,
    input  logic [NUM_PINS-1:0]        active,
    output logic [NUM_PINS-1:0]        sense_q,
    output logic [NUM_PINS*PRIO_W-1:0] prio_q,
    output logic [NUM_PINS-1:0]        clr,
    output logic [DATA_W-1:0]          rdata
);
    logic wr_ctrl, wr_prio;
    logic unused_wbits;

    // Decode writes to the two implemented words.
    always_comb begin
        wr_ctrl = wr_en && (addr == ADR_CTRL);
        wr_prio = wr_en && (addr == ADR_PRIO);
        clr     = wr_ctrl ? wdata[CLR_LSB +: NUM_PINS] : '0;
    end

    assign unused_wbits = ^wdata[DATA_W-1:CTRL_USED];

    // Store the sense-select bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       sense_q <= '0;
        else if (wr_ctrl) sense_q <= wdata[SENSE_LSB +: NUM_PINS];
    end

    // Store the priority codes.
    always_ff @(posedge clk) begin
        if (!rst_n)       prio_q <= '0;
        else if (wr_prio) prio_q <= wdata[PRIO_USED-1:0];
    end

    // Read mux; everything not listed returns zero.
    always_comb begin
        rdata = '0;
        if (addr == ADR_CTRL) begin
            rdata[SENSE_LSB  +: NUM_PINS] = sense_q;
            rdata[MIRROR_LSB +: NUM_PINS] = lvl;
            rdata[PEND_LSB   +: NUM_PINS] = active;
        end else if (addr == ADR_PRIO) begin
            rdata[PRIO_USED-1:0] = prio_q;
        end
    end
endmodule

// File: rtl/extirq_cond.sv
// Module: extirq_cond (top)
// Conditions two active-low interrupt pins into prioritized requests. Each pin
// has a synchronizer and a request channel. The low-power input forces level
// sensing. A request leaves the block only when its priority code is not 00.
// Assumes the pins are asynchronous and idle high.
module extirq_cond
    import extirq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PINS-1:0]        ext_n,
    input  logic                       lp_mode,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_PINS-1:0]        irq_o,
    output logic [NUM_PINS*PRIO_W-1:0] prio_o
);
    logic [NUM_PINS-1:0]        lvl, fall, pend_q, active, clr, sense_q, eff_edge;
    logic [NUM_PINS*PRIO_W-1:0] prio_q;

    irq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .lvl(lvl), .active(active), .sense_q(sense_q), .prio_q(prio_q),
        .clr(clr), .rdata(rdata)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_sync #(.STAGES(SYNC_LEN)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin_n(ext_n[i]),
            .level(lvl[i]), .fall(fall[i])
        );

        // Effective edge mode: the low-power state overrides the sense bit.
        assign eff_edge[i] = sense_q[i] & ~lp_mode;

        irq_channel u_chan (
            .clk(clk), .rst_n(rst_n), .edge_mode(eff_edge[i]),
            .level(lvl[i]), .fall(fall[i]), .clr(clr[i]),
            .pend_q(pend_q[i]), .active(active[i])
        );

        // Gate the request with a non-zero priority code.
        assign irq_o[i] = active[i] & (|prio_q[i*PRIO_W +: PRIO_W]);
    end

    assign prio_o = prio_q;
endmodule

// File: rtl/extirq_cond_chk.sv
// Module: extirq_cond_chk
// Checker for extirq_cond, attached with bind. It watches ports and top-level
// internal nets.
module extirq_cond_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lp_mode,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [1:0] clr,
    input logic [1:0] lvl,
    input logic [1:0] pend_q,
    input logic [1:0] irq_o,
    input logic [3:0] prio_o
);
    // R9
    irq_a_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] |-> (prio_o[1:0] != 2'b00));
    // R9
    irq_b_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[1] |-> (prio_o[3:2] != 2'b00));
    // R6
    lp_no_latch_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lp_mode) |-> !$rose(pend_q[0]));
    // R6
    lp_no_latch_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lp_mode) |-> !$rose(pend_q[1]));
    // R7
    pend_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[0] && !clr[0]) |=> pend_q[0]);
    // R7
    pend_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[1] && !clr[1]) |=> pend_q[1]);
    // R8
    prio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd1) |=> $stable(prio_o));
    // R3
    level_follow_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode && !lvl[0] && prio_o[1:0] != 2'b00) |-> irq_o[0]);
    // R3
    level_follow_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode && !lvl[1] && prio_o[3:2] != 2'b00) |-> irq_o[1]);
endmodule

bind extirq_cond extirq_cond_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .wr_en(wr_en), .addr(addr),
    .clr(clr), .lvl(lvl), .pend_q(pend_q), .irq_o(irq_o), .prio_o(prio_o)
);

// File: tb/sim_extirq_cond.sv
// Bench for extirq_cond: reset state, a full sweep of sense, low-power, priority
// and pin patterns, and directed tests for clear/edge collision and low-power hold.
module sim_extirq_cond;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_n = 2'b11;
    logic        lp_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic [1:0]  irq_o;
    logic [3:0]  prio_o;

    int n_vec = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    extirq_cond u0 (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .lp_mode(lp_mode),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_o(irq_o), .prio_o(prio_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 R2: reset state, mirrors read high, sense bits 0
        rd(2'd0, d); chk("R1/R2 reset ctrl", d, 16'h000C);
        // R8: priority codes reset to 00
        rd(2'd1, d); chk("R8 reset prio", d, 16'h0000);
        chk("R9 reset irq", {14'h0, irq_o}, 16'h0);

        // Sweep: priority codes x sense x low-power x pin pattern
        for (int pa = 0; pa < 4; pa++)
        for (int pb = 0; pb < 4; pb++)
        for (int sn = 0; sn < 4; sn++)
        for (int lp = 0; lp < 2; lp++)
        for (int pv = 0; pv < 4; pv++) begin
            logic [1:0] act, en, effe;
            lp_mode = lp[0];
            ext_n = 2'b11;
            cyc(4);
            wr(2'd1, {12'h0, pb[1:0], pa[1:0]});
            wr(2'd0, {10'h0, 2'b11, 2'b00, sn[1:0]});
            en = {pb != 0, pa != 0};
            effe = sn[1:0] & {2{~lp[0]}};
            ext_n = pv[1:0];
            cyc(4);
            act = ~pv[1:0];
            // R1 R2 R3 R4 R6: mirror, sense and request while pins are held
            rd(2'd0, d);
            chk("R1/R3/R4 ctrl pins held", d, {8'h0, act, 2'b00, pv[1:0], sn[1:0]});
            // R9: gating by priority code
            chk("R9 irq pins held", {14'h0, irq_o}, {14'h0, act & en});
            // R8: priority output layout
            chk("R8 prio_o", {12'h0, prio_o}, {12'h0, pb[1:0], pa[1:0]});
            ext_n = 2'b11;
            cyc(4);
            act = ~pv[1:0] & effe;
            // R3 R4 R6: only effective-edge pins remain pending after release
            rd(2'd0, d);
            chk("R4/R6 ctrl pins released", d, {8'h0, act, 2'b00, 2'b11, sn[1:0]});
            chk("R3/R9 irq pins released", {14'h0, irq_o}, {14'h0, act & en});
        end

        // R5: clear captured on the same edge the falling edge is detected
        lp_mode = 1'b0;
        ext_n = 2'b11;
        cyc(4);
        wr(2'd1, 16'h0005);
        wr(2'd0, 16'h0033);
        ext_n[0] = 1'b0;
        cyc(2);
        wr(2'd0, 16'h0013);
        rd(2'd0, d); chk("R5 edge beats clear", d & 16'h00C0, 16'h0040);
        wr(2'd0, 16'h0013);
        rd(2'd0, d); chk("R5 later clear", d & 16'h00C0, 16'h0000);
        chk("R5 irq after clear", {14'h0, irq_o}, 16'h0);

        // R7: pending flag held across entry to low power
        ext_n[0] = 1'b1;
        cyc(4);
        ext_n[0] = 1'b0;
        cyc(4);
        ext_n[0] = 1'b1;
        cyc(4);
        lp_mode = 1'b1;
        cyc(3);
        rd(2'd0, d); chk("R7 pending held in low power", d & 16'h00C0, 16'h0040);
        chk("R7 irq held", {14'h0, irq_o}, 16'h0001);
        wr(2'd0, 16'h0013);
        rd(2'd0, d); chk("R5/R7 clear in low power", d & 16'h00C0, 16'h0000);
        lp_mode = 1'b0;
        cyc(1);

        // R10: reserved bits and unused addresses
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); chk("R10 prio reserved", d, 16'h000F);
        wr(2'd0, 16'hFF0C);
        rd(2'd0, d); chk("R10 ctrl reserved", d, 16'h000C);
        wr(2'd2, 16'hFFFF);
        wr(2'd3, 16'hFFFF);
        rd(2'd2, d); chk("R10 addr 2", d, 16'h0000);
        rd(2'd3, d); chk("R10 addr 3", d, 16'h0000);
        rd(2'd1, d); chk("R10 prio untouched", d, 16'h000F);
        rd(2'd0, d); chk("R10 ctrl untouched", d, 16'h000C);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule